// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block narrows one 32-bit binary32 floating-point word to a 16-bit binary16 word. A word is accepted when the strobe is high, and the converted half and its four status flags appear on registered outputs one clock later. Finite values are rounded to nearest with ties going to the even result. Values too large for the half range saturate to a signed infinity. Values below the half normal range step down gradually into half subnormals and then to signed zero.

NaN inputs follow one of two policies, chosen per word by a mode input. In substitute mode every NaN becomes the single canonical half NaN. In propagate mode the sign is kept, the leading payload bits are carried over, and the result is forced quiet. A signalling NaN raises the invalid flag under either policy. The flags are inexact, overflow and underflow, so a surrounding pipeline can accumulate status without working out the rounding again.

Top module: `fcvt_s2h`

## Requirements
- R1: Results are registered. `out_valid` is high exactly one clock after a cycle in which `in_valid` was sampled high. While `in_valid` is low, `out_valid` is low and `out_half` and the flags keep their last values. A synchronous reset clears every output to zero.
- R2: Zero inputs give 0x0000 (positive) or 0x8000 (negative). Infinity inputs give 0x7c00 or 0xfc00. Neither case raises any flag.
- R3: For an input with unbiased exponent e in -14..15, the output exponent field (bits 14:10) is e+15 and the output fraction (bits 9:0) is the top 10 input fraction bits. The 13 dropped bits are rounded to nearest, with a tie (exactly 0x1000) going to an even fraction, and a carry from rounding increments the exponent. Inexact is set whenever any dropped bit is non-zero.
- R4: Overflow produces the signed infinity with the overflow and inexact flags set. Overflow occurs when e exceeds 15, or when rounding lifts the exponent field to 31. For example, 65504 converts exactly to 0x7bff, 65519 rounds down to 0x7bff, and 65520 overflows.
- R5: For e below -14, the result is a half subnormal counted in units of 2^-24 and rounded to nearest-even. The largest subnormal can round up to 0x0400. The underflow flag is set when e is below -14 and the result is inexact.
- R6: Magnitudes below 2^-25 give signed zero, and exactly 2^-25 ties to zero. Binary32 subnormal inputs always give signed zero, with inexact and underflow set.
- R7: With `dflt_nan` high, every NaN input (exponent all ones, fraction non-zero) gives exactly 0x7e00.
- R8: With `dflt_nan` low, a NaN input gives the input sign, exponent field 31, bit 9 forced to 1, and bits 8:0 equal to input fraction bits 21:13.
- R9: `out_invalid` is set only for a signalling NaN input, meaning input bit 22 is clear, under either NaN policy. A quiet NaN or any non-NaN input leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: convert `in_word` this cycle |
| in_word | input | 32 | binary32 operand |
| dflt_nan | input | 1 | 1: NaNs become 0x7e00; 0: NaN payload propagated |
| out_valid | output | 1 | Result registered from the previous cycle |
| out_half | output | 16 | binary16 result |
| out_invalid | output | 1 | Signalling NaN seen |
| out_inexact | output | 1 | Result differs from the operand |
| out_overflow | output | 1 | Result saturated to infinity |
| out_underflow | output | 1 | Tiny operand with an inexact result |

## Verification
Two pairs of behaviours can fire on the same conversion. Rounding up can produce a carry that overflows (65520 becomes infinity with both overflow and inexact set). The subnormal path can round into the normal range while still reporting underflow (0x387fe000 becomes 0x0400 with underflow set). Both pairs are driven with directed words whose tie bits sit exactly at the rounding point, and the bench judges the half and all four flags against its own integer model. Random words are biased toward the overflow and subnormal exponent bands so that these coincidences also occur with varied fractions.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    // binary32 operand format
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int SP_BIAS   = 127;
    localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;

    // binary16 result format
    localparam int HP_EXP_W  = 5;
    localparam int HP_FRAC_W = 10;
    localparam int HP_BIAS   = 15;
    localparam int HP_W      = 1 + HP_EXP_W + HP_FRAC_W;

    // derived datapath sizes
    localparam int FRAC_DROP = SP_FRAC_W - HP_FRAC_W;      // 13 bits rounded away
    localparam int SIG_W     = SP_FRAC_W + 1;              // significand with hidden one
    localparam int EU_W      = SP_EXP_W + 2;               // signed unbiased exponent
    localparam int HP_EMIN   = 1 - HP_BIAS;                // -14
    localparam int HP_EMAX   = HP_BIAS;                    // 15
    localparam int SH_MAX    = SIG_W + 2;                  // beyond this only sticky remains
    localparam int SH_W      = $clog2(SH_MAX + 1);
    localparam int WIDE_W    = SIG_W + SH_MAX;
    localparam int ENC_W     = SIG_W + 1;

    localparam logic [HP_W-2:0] HP_INF_MAG = {{HP_EXP_W{1'b1}}, {HP_FRAC_W{1'b0}}};
    localparam logic [HP_W-1:0] HP_QNAN_DFLT =
        {1'b0, {HP_EXP_W{1'b1}}, 1'b1, {(HP_FRAC_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CLS_ZERO, CLS_TINY_IN, CLS_FINITE, CLS_INF, CLS_QNAN, CLS_SNAN
    } fclass_e;

    typedef struct packed {
        logic                 sgn;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_word_t;

    typedef struct packed {
        logic [HP_W-1:0] bits;
        logic            invalid;
        logic            inexact;
        logic            overflow;
        logic            underflow;
    } hp_result_t;

    function automatic fclass_e classify(input sp_word_t w);
        if (w.exp == '0)
            return (w.frac == '0) ? CLS_ZERO : CLS_TINY_IN;
        if (w.exp == '1) begin
            if (w.frac == '0) return CLS_INF;
            return w.frac[SP_FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        end
        return CLS_FINITE;
    endfunction

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  sp_word_t                w,
    output fclass_e                 cls,
    output logic signed [EU_W-1:0]  e_unb,
    output logic [SIG_W-1:0]        sig
);
    always_comb begin
        cls   = classify(w);
        e_unb = $signed({2'b00, w.exp}) - EU_W'(SP_BIAS);
        sig   = {1'b1, w.frac};
    end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  logic                    sgn,
    input  logic signed [EU_W-1:0]  e_unb,
    input  logic [SIG_W-1:0]        sig,
    output hp_result_t              res
);
    logic                   too_big;
    logic                   tiny;
    logic signed [EU_W-1:0] nsh;
    logic [SH_W-1:0]        sh;
    logic [WIDE_W-1:0]      wide;
    logic [SIG_W-1:0]       kept;
    logic                   guard_b;
    logic                   sticky_b;
    logic                   rnd_up;
    logic [HP_EXP_W-1:0]    tgt_exp;
    logic [ENC_W-1:0]       enc;
    logic                   ovf;

    always_comb begin
        too_big = e_unb > EU_W'(HP_EMAX);
        tiny    = e_unb < EU_W'(HP_EMIN);
        // distance from the operand exponent down to the subnormal scale
        nsh     = EU_W'(HP_EMIN) - e_unb + EU_W'(FRAC_DROP);
        if (!tiny)
            sh = SH_W'(FRAC_DROP);
        else if (nsh > EU_W'(SH_MAX))
            sh = SH_W'(SH_MAX);
        else
            sh = nsh[SH_W-1:0];

        wide     = {sig, {SH_MAX{1'b0}}} >> sh;
        kept     = wide[WIDE_W-1 -: SIG_W];
        guard_b  = wide[SH_MAX-1];
        sticky_b = |wide[SH_MAX-2:0];
        rnd_up   = guard_b & (sticky_b | kept[0]);

        // subnormals use the minimum exponent scale; the hidden one then cancels
        tgt_exp  = tiny ? HP_EXP_W'(1) : HP_EXP_W'(e_unb + EU_W'(HP_BIAS));
        enc      = ENC_W'({tgt_exp, {HP_FRAC_W{1'b0}}}) + ENC_W'(kept)
                 - ENC_W'(1 << HP_FRAC_W) + ENC_W'(rnd_up);
        ovf      = too_big | (enc >= ENC_W'(HP_INF_MAG));

        res.bits      = ovf ? {sgn, HP_INF_MAG} : {sgn, enc[HP_W-2:0]};
        res.invalid   = 1'b0;
        res.inexact   = guard_b | sticky_b | too_big;
        res.overflow  = ovf;
        res.underflow = tiny & (guard_b | sticky_b);
    end
endmodule

// File: rtl/fcvt_s2h.sv
module fcvt_s2h
    import fcvt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [SP_W-1:0] in_word,
    input  logic            dflt_nan,
    output logic            out_valid,
    output logic [HP_W-1:0] out_half,
    output logic            out_invalid,
    output logic            out_inexact,
    output logic            out_overflow,
    output logic            out_underflow
);
    sp_word_t               w;
    fclass_e                cls;
    logic signed [EU_W-1:0] e_unb;
    logic [SIG_W-1:0]       sig;
    hp_result_t             rnd_res;
    hp_result_t             nxt;
    hp_result_t             res_q;
    logic                   v_q;

    assign w = sp_word_t'(in_word);

    fcvt_unpack u_unpack (.w(w), .cls(cls), .e_unb(e_unb), .sig(sig));
    fcvt_round  u_round  (.sgn(w.sgn), .e_unb(e_unb), .sig(sig), .res(rnd_res));

    always_comb begin
        nxt = '0;
        unique case (cls)
            CLS_ZERO:    nxt.bits = {w.sgn, {(HP_W-1){1'b0}}};
            CLS_INF:     nxt.bits = {w.sgn, HP_INF_MAG};
            CLS_TINY_IN: begin
                nxt.bits      = {w.sgn, {(HP_W-1){1'b0}}};
                nxt.inexact   = 1'b1;
                nxt.underflow = 1'b1;
            end
            CLS_QNAN, CLS_SNAN: begin
                nxt.invalid = (cls == CLS_SNAN);
                nxt.bits    = dflt_nan ? HP_QNAN_DFLT
                            : {w.sgn, {HP_EXP_W{1'b1}}, 1'b1,
                               w.frac[SP_FRAC_W-2 -: HP_FRAC_W-1]};
            end
            default: nxt = rnd_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            res_q <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) res_q <= nxt;
        end
    end

    assign out_valid     = v_q;
    assign out_half      = res_q.bits;
    assign out_invalid   = res_q.invalid;
    assign out_inexact   = res_q.inexact;
    assign out_overflow  = res_q.overflow;
    assign out_underflow = res_q.underflow;

    // ---------------- assertions ----------------
    logic in_is_nan;
    assign in_is_nan = (in_word[30:23] == '1) && (in_word[22:0] != '0);

    p_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_half) && $stable(out_inexact)));
    p_ovf_is_inf_r4: assert property (@(posedge clk) disable iff (rst)
        out_overflow |-> (out_inexact && out_half[14:0] == 15'h7c00));
    p_unf_inexact_r5: assert property (@(posedge clk) disable iff (rst)
        out_underflow |-> out_inexact);
    p_dflt_nan_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dflt_nan && in_is_nan) |=> out_half == 16'h7e00);
    p_quiet_prop_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dflt_nan && in_is_nan) |=>
        (out_half[9] && out_half[14:10] == 5'h1f && out_half[15] == $past(in_word[31])));
    p_invalid_snan_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_invalid == $past(in_is_nan && !in_word[22]));
    p_sign_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(dflt_nan && in_is_nan)) |=> out_half[15] == $past(in_word[31]));
endmodule

// File: tb/sim_fcvt_s2h.sv
module sim_fcvt_s2h;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        dflt_nan = 1'b0;
    logic        out_valid;
    logic [15:0] out_half;
    logic        out_invalid, out_inexact, out_overflow, out_underflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcvt_s2h u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .dflt_nan(dflt_nan), .out_valid(out_valid), .out_half(out_half),
        .out_invalid(out_invalid), .out_inexact(out_inexact),
        .out_overflow(out_overflow), .out_underflow(out_underflow)
    );

    // model: {half, invalid, inexact, overflow, underflow}
    function automatic logic [19:0] model(input logic [31:0] wd, input logic dn);
        logic   s;
        logic   nv;
        longint ex, e, te, k, sg, q, rem, hf, mag, enc;
        logic   inx, up, ovf, unf;
        s  = wd[31];
        ex = longint'(wd[30:23]);
        if (ex == 255) begin
            if (wd[22:0] == 0) return {s, 15'h7c00, 4'b0000};
            nv = !wd[22];
            if (dn) return {16'h7e00, nv, 3'b000};
            return {s, 5'h1f, 1'b1, wd[21:13], nv, 3'b000};
        end
        if (ex == 0) begin
            if (wd[22:0] == 0) return {s, 15'h0000, 4'b0000};
            return {s, 15'h0000, 4'b0101};
        end
        e  = ex - 127;
        sg = longint'(wd[22:0]) + (64'sd1 <<< 23);
        if (e > 15) return {s, 15'h7c00, 4'b0110};
        te = (e < -14) ? -14 : e;
        k  = te - e + 13;
        if (k >= 40) begin
            q = 0; inx = 1'b1; up = 1'b0;
        end else begin
            q   = sg >>> k;
            rem = sg - (q <<< k);
            hf  = 64'sd1 <<< (k - 1);
            inx = (rem != 0);
            up  = (rem > hf) || ((rem == hf) && q[0]);
        end
        mag = q + longint'(up);
        enc = ((te + 15) <<< 10) + mag - 1024;
        ovf = 1'b0;
        if (enc >= 64'h7c00) begin
            enc = 64'h7c00; ovf = 1'b1; inx = 1'b1;
        end
        unf = (e < -14) && inx;
        return {s, enc[14:0], 1'b0, inx, ovf, unf};
    endfunction

    task automatic judge(input string req, input logic [19:0] exp_v);
        logic [19:0] act;
        act = {out_half, out_invalid, out_inexact, out_overflow, out_underflow};
        n_checks++;
        if (act !== exp_v || out_valid !== 1'b1) begin
            n_fails++;
            $display("FAIL %s: got half=%h flags=%b valid=%b, expected half=%h flags=%b valid=1",
                     req, act[19:4], act[3:0], out_valid, exp_v[19:4], exp_v[3:0]);
        end
    endtask

    task automatic convert(input logic [31:0] wd, input logic dn);
        @(negedge clk);
        in_word  = wd;
        dflt_nan = dn;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // directed: hard expected half, flags from the model
    task automatic directed(input string req, input logic [31:0] wd, input logic dn,
                            input logic [15:0] half_exp);
        logic [19:0] m;
        m = model(wd, dn);
        convert(wd, dn);
        judge(req, {half_exp, m[3:0]});
    endtask

    function automatic logic [31:0] pick_word();
        logic [31:0] r;
        int          sel;
        r   = $urandom;
        sel = $urandom_range(0, 7);
        case (sel)
            0: r[30:23] = 8'hff;
            1: r[30:23] = 8'(142 + $urandom_range(0, 1));
            2: r[30:23] = 8'(100 + $urandom_range(0, 13));
            3: r[30:23] = 8'(110 + $urandom_range(0, 5));
            4: begin r[30:23] = 8'(142); r[22:12] = 11'h7ff; end
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        n_checks++;
        if ({out_valid, out_half, out_invalid, out_inexact, out_overflow, out_underflow} !== '0) begin
            n_fails++;
            $display("FAIL R1 reset: got valid=%b half=%h, expected valid=0 half=0000",
                     out_valid, out_half);
        end

        directed("R2 neg zero",        32'h80000000, 1'b0, 16'h8000);
        directed("R2 neg inf",         32'hff800000, 1'b0, 16'hfc00);
        directed("R3 one",             32'h3f800000, 1'b0, 16'h3c00);
        directed("R3 tie even down",   32'h3f801000, 1'b0, 16'h3c00);
        directed("R3 tie odd up",      32'h3f803000, 1'b0, 16'h3c02);
        directed("R4 max finite",      32'h477fe000, 1'b0, 16'h7bff);
        directed("R4 just below",      32'h477fef00, 1'b0, 16'h7bff);
        directed("R4 65520 overflow",  32'h477ff000, 1'b0, 16'h7c00);
        directed("R4 neg overflow",    32'hc77ff000, 1'b0, 16'hfc00);
        directed("R4 huge",            32'h50000000, 1'b0, 16'h7c00);
        directed("R5 min subnormal",   32'h33800000, 1'b0, 16'h0001);
        directed("R5 exact subnormal", 32'h34400000, 1'b0, 16'h0003);
        directed("R5 carry to normal", 32'h387fe000, 1'b0, 16'h0400);
        directed("R5 above half unit", 32'h33000001, 1'b0, 16'h0001);
        directed("R6 tie to zero",     32'h33000000, 1'b0, 16'h0000);
        directed("R6 input subnormal", 32'h80000001, 1'b0, 16'h8000);
        directed("R7 snan default",    32'h7f800001, 1'b1, 16'h7e00);
        directed("R7 qnan default",    32'hffc12345, 1'b1, 16'h7e00);
        directed("R8 qnan propagate",  32'hffc12345, 1'b0, 16'hfe09);
        directed("R9 snan propagate",  32'h7f800001, 1'b0, 16'h7e00);

        // R1 hold: strobe low, operand changes, output must not move
        begin
            logic [15:0] held;
            held = out_half;
            @(negedge clk);
            in_word = 32'h3f800000;
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_half !== held) begin
                n_fails++;
                $display("FAIL R1 hold: got valid=%b half=%h, expected valid=0 half=%h",
                         out_valid, out_half, held);
            end
        end

        // random sweep: R2..R9 against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic        dn;
            wd = pick_word();
            dn = 1'($urandom_range(0, 1));
            convert(wd, dn);
            judge($sformatf("R3-R9 random %h dn=%0d", wd, dn), model(wd, dn));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule